// File: doc/BRIEF.md
# Configurable UART Transmit Path

This block turns bytes into an asynchronous serial stream. Software-side logic loads bytes into a 16-entry queue. A serializer takes them one at a time and sends a frame on `txd`. The frame is a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two high stop bits. The line rests high. A 16-bit divisor sets the bit timing. Each bit lasts 16 baud ticks, or 8 ticks in fast mode.

A set of static configuration inputs controls the transmitter. The global enable and the transmit enable must both be set for a frame to start. Clearing either one lets the frame on the wire finish. A raw interrupt flag has two meanings, chosen by one input. In one mode it rises when the queue drains down to a chosen fill level. In the other it rises when the last stop bit has left the line with nothing queued. A card-interface mode fixes the frame format and stops all transmission when the far end reports a parity error. A loopback input turns the block's receive-side output into a copy of its own transmit line.

Top module: `uart_tx_path`

## Requirements
- R1: After reset `txd` is 1, `tx_int` is 0 and `wr_full` is 0.
- R2: A frame on `txd` is a 0 start bit, then data bits LSB first, then the parity bit if enabled, then stop bits at 1. The data width is `cfg_wlen`+5 bits (codes 0..3 give 5..8). The parity bit gives an even count of ones over data and parity when `cfg_par_even`=1, and an odd count when it is 0. There are two stop bits when `cfg_two_stop`=1 and one otherwise. While no frame is in progress `txd` is 1.
- R3: Each bit lasts OSR×(`cfg_div`+1) clock cycles. OSR is 16 with `cfg_fast`=0 and 8 with `cfg_fast`=1. With `cfg_div`=0 no frame starts and queued bytes wait.
- R4: A frame starts only while `cfg_en`=1 and `cfg_txen`=1. If either is 0, queued bytes stay in the queue and the line stays at 1.
- R5: Clearing `cfg_txen` or `cfg_en` while a frame is in progress lets that frame finish with all of its stop bits. After that no new frame starts.
- R6: With `cfg_eot`=0, `tx_int` sets when a byte leaves the queue and brings the fill level from threshold+1 down to the threshold. The threshold for `cfg_thr` codes 0,1,2,3,4 is 2,4,8,12,14 entries; codes 5..7 give 14. Further pops below the threshold do not set it again.
- R7: With `cfg_eot`=1, `tx_int` sets on the clock edge at which the last stop bit ends, if the queue is empty. It reads 1 exactly F×OSR×(`cfg_div`+1) cycles after the start bit begins, where F is the number of bits in the frame.
- R8: With `cfg_smart`=1 every frame has 8 data bits, even parity and two stop bits, whatever `cfg_wlen`, `cfg_par_en`, `cfg_par_even` and `cfg_two_stop` say.
- R9: With `cfg_smart`=1, a 1 on `par_err` halts the transmitter. The frame in progress finishes, and no later frame starts until a pulse on `abort_clr`. With `cfg_smart`=0, `par_err` is ignored.
- R10: With `cfg_loop`=1, `rx_in` follows `txd`. With `cfg_loop`=0, `rx_in` follows `rxd_pin`.
- R11: The queue holds 16 bytes. `wr_full` is 1 when it holds 16, and a write while it is full is dropped.
- R12: A 1 on `int_clr` clears `tx_int` at the next edge, unless a set condition occurs on that same edge; a set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Global enable |
| cfg_txen | input | 1 | Transmit enable |
| cfg_fast | input | 1 | 8 ticks per bit instead of 16 |
| cfg_eot | input | 1 | Interrupt on line drained instead of queue threshold |
| cfg_loop | input | 1 | Route the transmit line to `rx_in` |
| cfg_smart | input | 1 | Card-interface mode |
| cfg_wlen | input | 2 | Data width code, width = code+5 |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_even | input | 1 | Even parity when 1, odd when 0 |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_div | input | 16 | Baud divisor, a tick every div+1 clocks |
| cfg_thr | input | 3 | Queue threshold code |
| wr_valid | input | 1 | Write a byte into the queue |
| wr_data | input | 8 | Byte to write |
| wr_full | output | 1 | Queue holds 16 bytes |
| int_clr | input | 1 | Write-one-to-clear for `tx_int` |
| tx_int | output | 1 | Raw transmit interrupt |
| par_err | input | 1 | Far end reports a parity error |
| abort_clr | input | 1 | Release a halt caused by `par_err` |
| txd | output | 1 | Serial transmit line |
| rxd_pin | input | 1 | External receive line |
| rx_in | output | 1 | Receive-side serial input |

## Verification
The assertions check, on every cycle, these rules:
- the line is high whenever the serializer is idle;
- every frame opens with a low level;
- no byte leaves the queue while disabled, while the divisor is zero or while halted;
- the queue level never passes its depth;
- a parity error halts the block and `abort_clr` releases it;
- clearing and setting the interrupt obey their priority.

Other behaviours can only be shown by the bench's scenarios:
- the bit values and exact bit timing for each format;
- a frame finishing after its enable drops;
- the interrupt rising on the exact edge where a frame ends, or the pop that crosses the threshold;
- forced card-interface framing;
- a byte dropped when the queue is full.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_START,
      TS_DATA,
      TS_PAR,
      TS_STOP
   } tx_state_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       par_en;
      logic       par_even;
      logic       two_stop;
   } frame_fmt_t;

   // queue fill level that a threshold code stands for
   function automatic int unsigned thr_fill(input logic [2:0] code, input int unsigned depth);
      case (code)
         3'd0:    return depth / 8;
         3'd1:    return depth / 4;
         3'd2:    return depth / 2;
         3'd3:    return (depth * 6) / 8;
         default: return (depth * 7) / 8;
      endcase
   endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (DIV_W < 2) begin : g_bad_width
      $error("uart_tx_baud: DIV_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             div_zero;

   assign div_zero = (div == '0);
   assign tick     = !div_zero && (cnt_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (sync || tick || div_zero) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
   parameter  int DEPTH  = 16,
   parameter  int DATA_W = 8,
   localparam int AW     = $clog2(DEPTH),
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic [LVL_W-1:0]  level
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_tx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [AW-1:0]     wptr_q, rptr_q;
   logic              push, take;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push    = wr_valid && !full;
   assign take    = pop && !empty;
   assign rd_data = mem_q[rptr_q];

   always_ff @(posedge clk) begin
      if (push) begin
         mem_q[wptr_q] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         level  <= '0;
      end else begin
         if (push) wptr_q <= wptr_q + 1'b1;
         if (take) rptr_q <= rptr_q + 1'b1;
         case ({push, take})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter  int SLOW_OSR = 16,
   parameter  int FAST_OSR = 8,
   localparam int SUB_W    = $clog2(SLOW_OSR)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       can_start,
   input  logic       fast,
   input  logic       smart,
   input  frame_fmt_t fmt,
   input  logic [7:0] din,
   output logic       pop,
   output logic       txd,
   output logic       busy,
   output logic       frame_done
);

   if (FAST_OSR < 2 || FAST_OSR > SLOW_OSR) begin : g_bad_osr
      $error("uart_tx_shift: need 2 <= FAST_OSR <= SLOW_OSR");
   end

   tx_state_e        state_q;
   logic [7:0]       sh_q;
   logic [2:0]       idx_q, dlast_q;
   logic [SUB_W-1:0] sub_q, sub_last;
   logic             par_q, use_par_q, two_q, fast_q, stop2_q;

   logic [2:0]       dlast_d;
   logic [7:0]       mask_d, load_d;
   logic             par_d, even_d, bit_end;

   // format seen at load time; card mode overrides the programmed fields
   always_comb begin
      dlast_d = smart ? 3'd7 : (3'd4 + {1'b0, fmt.wlen});
      mask_d  = 8'hFF >> (3'd7 - dlast_d);
      load_d  = din & mask_d;
      even_d  = smart || fmt.par_even;
      par_d   = even_d ? (^load_d) : ~(^load_d);
   end

   assign sub_last   = fast_q ? SUB_W'(FAST_OSR - 1) : SUB_W'(SLOW_OSR - 1);
   assign bit_end    = tick && (sub_q == sub_last);
   assign pop        = (state_q == TS_IDLE) && can_start;
   assign busy       = (state_q != TS_IDLE);
   assign frame_done = (state_q == TS_STOP) && bit_end && (!two_q || stop2_q);

   always_comb begin
      case (state_q)
         TS_START: txd = 1'b0;
         TS_DATA:  txd = sh_q[0];
         TS_PAR:   txd = par_q;
         default:  txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= TS_IDLE;
         sh_q      <= '0;
         idx_q     <= '0;
         dlast_q   <= '0;
         sub_q     <= '0;
         par_q     <= 1'b0;
         use_par_q <= 1'b0;
         two_q     <= 1'b0;
         fast_q    <= 1'b0;
         stop2_q   <= 1'b0;
      end else if (state_q == TS_IDLE) begin
         if (pop) begin
            state_q   <= TS_START;
            sh_q      <= load_d;
            dlast_q   <= dlast_d;
            par_q     <= par_d;
            use_par_q <= smart || fmt.par_en;
            two_q     <= smart || fmt.two_stop;
            fast_q    <= fast;
            sub_q     <= '0;
            idx_q     <= '0;
            stop2_q   <= 1'b0;
         end
      end else if (tick) begin
         if (!bit_end) begin
            sub_q <= sub_q + 1'b1;
         end else begin
            sub_q <= '0;
            case (state_q)
               TS_START: begin
                  state_q <= TS_DATA;
                  idx_q   <= '0;
               end
               TS_DATA: begin
                  sh_q <= {1'b0, sh_q[7:1]};
                  if (idx_q == dlast_q) begin
                     state_q <= use_par_q ? TS_PAR : TS_STOP;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
               TS_PAR: begin
                  state_q <= TS_STOP;
                  stop2_q <= 1'b0;
               end
               TS_STOP: begin
                  if (two_q && !stop2_q) begin
                     stop2_q <= 1'b1;
                  end else begin
                     state_q <= TS_IDLE;
                  end
               end
               default: state_q <= TS_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
   import uart_tx_pkg::*;
#(
   parameter  int FIFO_DEPTH = 16,
   parameter  int DIV_W      = 16,
   parameter  int SLOW_OSR   = 16,
   parameter  int FAST_OSR   = 8,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_txen,
   input  logic             cfg_fast,
   input  logic             cfg_eot,
   input  logic             cfg_loop,
   input  logic             cfg_smart,
   input  logic [1:0]       cfg_wlen,
   input  logic             cfg_par_en,
   input  logic             cfg_par_even,
   input  logic             cfg_two_stop,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [2:0]       cfg_thr,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   output logic             wr_full,
   input  logic             int_clr,
   output logic             tx_int,
   input  logic             par_err,
   input  logic             abort_clr,
   output logic             txd,
   input  logic             rxd_pin,
   output logic             rx_in
);

   if (FIFO_DEPTH < 8) begin : g_bad_depth
      $error("uart_tx_path: FIFO_DEPTH below 8 leaves thresholds undefined");
   end

   logic             tick, pop, busy, frame_done;
   logic             fifo_empty;
   logic [7:0]       fifo_data;
   logic [LVL_W-1:0] fifo_level, thr_lvl;
   logic             halted_q, can_start, int_set, thr_cross;
   frame_fmt_t       fmt;

   assign fmt = '{wlen: cfg_wlen, par_en: cfg_par_en, par_even: cfg_par_even,
                  two_stop: cfg_two_stop};

   uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .sync (pop),
      .div  (cfg_div),
      .tick (tick)
   );

   uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(wr_valid),
      .wr_data (wr_data),
      .pop     (pop),
      .rd_data (fifo_data),
      .empty   (fifo_empty),
      .full    (wr_full),
      .level   (fifo_level)
   );

   uart_tx_shift #(.SLOW_OSR(SLOW_OSR), .FAST_OSR(FAST_OSR)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .can_start (can_start),
      .fast      (cfg_fast),
      .smart     (cfg_smart),
      .fmt       (fmt),
      .din       (fifo_data),
      .pop       (pop),
      .txd       (txd),
      .busy      (busy),
      .frame_done(frame_done)
   );

   assign can_start = cfg_en && cfg_txen && !halted_q && !fifo_empty && (cfg_div != '0);

   // halt after a far-end parity complaint in card mode
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
      end else if (cfg_smart && par_err) begin
         halted_q <= 1'b1;
      end else if (abort_clr) begin
         halted_q <= 1'b0;
      end
   end

   always_comb begin
      thr_lvl   = LVL_W'(thr_fill(cfg_thr, FIFO_DEPTH));
      thr_cross = pop && !(wr_valid && !wr_full) && (fifo_level == thr_lvl + LVL_W'(1));
      int_set   = cfg_eot ? (frame_done && fifo_empty) : thr_cross;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_int <= 1'b0;
      end else if (int_set) begin
         tx_int <= 1'b1;
      end else if (int_clr) begin
         tx_int <= 1'b0;
      end
   end

   assign rx_in = cfg_loop ? txd : rxd_pin;

endmodule

// File: rtl/uart_tx_path_chk.sv
module uart_tx_path_chk #(
   parameter int FIFO_DEPTH = 16,
   parameter int DIV_W      = 16,
   parameter int LVL_W      = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             txd,
   input logic             busy,
   input logic             pop,
   input logic             cfg_en,
   input logic             cfg_txen,
   input logic [DIV_W-1:0] cfg_div,
   input logic             cfg_smart,
   input logic             par_err,
   input logic             abort_clr,
   input logic             halted,
   input logic [LVL_W-1:0] level,
   input logic             int_set,
   input logic             int_clr,
   input logic             tx_int
);

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd); // R2

   AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd); // R2

   AST_START_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cfg_en && cfg_txen)); // R4

   AST_START_NEEDS_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cfg_div != '0)); // R3

   AST_HALT_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !pop); // R9

   AST_PARITY_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_smart && par_err) |=> halted); // R9

   AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_clr && !(cfg_smart && par_err)) |=> !halted); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= FIFO_DEPTH); // R11

   AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (int_clr && !int_set) |=> !tx_int); // R12

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      int_set |=> tx_int); // R12

endmodule

bind uart_tx_path uart_tx_path_chk #(
   .FIFO_DEPTH(FIFO_DEPTH),
   .DIV_W     (DIV_W),
   .LVL_W     (LVL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .txd      (txd),
   .busy     (busy),
   .pop      (pop),
   .cfg_en   (cfg_en),
   .cfg_txen (cfg_txen),
   .cfg_div  (cfg_div),
   .cfg_smart(cfg_smart),
   .par_err  (par_err),
   .abort_clr(abort_clr),
   .halted   (halted_q),
   .level    (fifo_level),
   .int_set  (int_set),
   .int_clr  (int_clr),
   .tx_int   (tx_int)
);

// File: tb/uart_tx_path_test.sv
module uart_tx_path_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        cfg_en = 1'b1, cfg_txen = 1'b1, cfg_fast = 1'b1, cfg_eot = 1'b1;
   logic        cfg_loop = 1'b0, cfg_smart = 1'b0;
   logic [1:0]  cfg_wlen = 2'd3;
   logic        cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0;
   logic [15:0] cfg_div = 16'd1;
   logic [2:0]  cfg_thr = 3'd0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic        int_clr = 1'b0, par_err = 1'b0, abort_clr = 1'b0, rxd_pin = 1'b1;
   logic        wr_full, tx_int, txd, rx_in;

   uart_tx_path uut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_txen(cfg_txen),
      .cfg_fast(cfg_fast), .cfg_eot(cfg_eot), .cfg_loop(cfg_loop),
      .cfg_smart(cfg_smart), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
      .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
      .cfg_div(cfg_div), .cfg_thr(cfg_thr), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_full(wr_full), .int_clr(int_clr),
      .tx_int(tx_int), .par_err(par_err), .abort_clr(abort_clr),
      .txd(txd), .rxd_pin(rxd_pin), .rx_in(rx_in)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---- reference model of the frame, from the requirements ----
   function automatic int osr();
      return cfg_fast ? 8 : 16;
   endfunction
   function automatic int dbits();
      return cfg_smart ? 8 : int'(cfg_wlen) + 5;
   endfunction
   function automatic bit haspar();
      return cfg_smart || cfg_par_en;
   endfunction
   function automatic int flen();
      return 1 + dbits() + int'(haspar()) + ((cfg_smart || cfg_two_stop) ? 2 : 1);
   endfunction
   function automatic bit fbit(input logic [7:0] d, input int i);
      bit p;
      if (i == 0) return 1'b0;
      if (i <= dbits()) return d[i-1];
      if (haspar() && i == dbits() + 1) begin
         p = 1'b0;
         for (int k = 0; k < dbits(); k++) p ^= d[k];
         return (cfg_smart || cfg_par_even) ? p : ~p;
      end
      return 1'b1;
   endfunction

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      int_clr = 1'b1;
      @(negedge clk);
      int_clr = 1'b0;
   endtask

   task automatic wait_fall(output bit ok);
      ok = 1'b0;
      for (int t = 0; t < 30000; t++) begin
         @(negedge clk);
         if (txd === 1'b0) begin
            ok = 1'b1;
            return;
         end
      end
   endtask

   // sample every bit mid-period; in line-drained mode check the flag edge
   task automatic capture(input logic [7:0] d, input string req, input bit clr_end);
      bit ok;
      int bp, f, bad;
      bp  = osr() * (int'(cfg_div) + 1);
      f   = flen();
      bad = 0;
      wait_fall(ok);
      if (!ok) begin
         check(1'b0, {req, " no frame"}, 0, 1);
         return;
      end
      for (int i = 0; i <= f * bp; i++) begin
         if (i > 0) @(negedge clk);
         if (i < f * bp && (i % bp) == bp / 2 && txd !== fbit(d, i / bp)) bad++;
         if (cfg_eot && i == f * bp - 1 && tx_int !== 1'b0) bad++;
         if (clr_end && i == f * bp - 1) int_clr = 1'b1;
         if (i == f * bp) begin
            int_clr = 1'b0;
            if (cfg_eot && tx_int !== 1'b1) bad++;
         end
      end
      check(bad == 0, req, bad, 0);
   endtask

   task automatic send1(input logic [7:0] d, input string req);
      pulse_clr();
      push(d);
      capture(d, req, 1'b0);
   endtask

   task automatic quiet(input int n, input string req);
      int lows;
      lows = 0;
      repeat (n) begin
         @(negedge clk);
         if (txd !== 1'b1) lows++;
      end
      check(lows == 0, req, lows, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(txd === 1'b1, "R1 txd", int'(txd), 1);
      check(tx_int === 1'b0, "R1 tx_int", int'(tx_int), 0);
      check(wr_full === 1'b0, "R1 wr_full", int'(wr_full), 0);

      // R2 R7 basic 8N1 fast
      send1(8'hA5, "R2 R7 8N1");
      // R3 R7 slow rate, 7 bits, odd parity, two stops
      cfg_fast = 1'b0; cfg_div = 16'd2; cfg_wlen = 2'd2; cfg_par_en = 1'b1; cfg_two_stop = 1'b1;
      send1(8'h3C, "R3 R7 7O2 slow");
      cfg_fast = 1'b1; cfg_div = 16'd1; cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;

      // R3 divisor zero holds the line
      cfg_div = 16'd0;
      pulse_clr();
      push(8'h5A);
      quiet(500, "R3 div zero");
      cfg_div = 16'd1;
      capture(8'h5A, "R3 div restored", 1'b0);

      // R4 each enable gates the start
      cfg_en = 1'b0;
      pulse_clr();
      push(8'h11);
      quiet(400, "R4 global off");
      cfg_en = 1'b1;
      capture(8'h11, "R4 global on", 1'b0);
      cfg_txen = 1'b0;
      pulse_clr();
      push(8'h22);
      quiet(400, "R4 tx off");
      cfg_txen = 1'b1;
      capture(8'h22, "R4 tx on", 1'b0);

      // R5 disable mid-frame
      cfg_eot = 1'b0;
      cfg_txen = 1'b0;
      push(8'hC3);
      push(8'h3C);
      cfg_txen = 1'b1;
      fork
         capture(8'hC3, "R5 frame completes", 1'b0);
         begin
            repeat (60) @(negedge clk);
            cfg_txen = 1'b0;
         end
      join
      quiet(400, "R5 stays idle");
      cfg_txen = 1'b1;
      capture(8'h3C, "R5 resumes", 1'b0);

      // R6 threshold crossing (code 0 -> 2 entries)
      cfg_thr = 3'd0;
      pulse_clr();
      cfg_txen = 1'b0;
      for (int i = 0; i < 4; i++) push(8'h40 + 8'(i));
      check(tx_int === 1'b0, "R6 above threshold", int'(tx_int), 0);
      cfg_txen = 1'b1;
      capture(8'h40, "R6 frame0", 1'b0);
      check(tx_int === 1'b0, "R6 level 3", int'(tx_int), 0);
      capture(8'h41, "R6 frame1", 1'b0);
      check(tx_int === 1'b1, "R6 level 2", int'(tx_int), 1);
      pulse_clr();
      check(tx_int === 1'b0, "R12 clear", int'(tx_int), 0);
      capture(8'h42, "R6 frame2", 1'b0);
      capture(8'h43, "R6 frame3", 1'b0);
      check(tx_int === 1'b0, "R6 no re-set below", int'(tx_int), 0);

      // R12 set wins over a clear on the same edge
      cfg_eot = 1'b1;
      pulse_clr();
      push(8'h6E);
      capture(8'h6E, "R12 set wins", 1'b1);
      pulse_clr();
      check(tx_int === 1'b0, "R12 clear after", int'(tx_int), 0);

      // R8 card mode forces 8E2
      cfg_smart = 1'b1; cfg_wlen = 2'd0; cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_two_stop = 1'b0;
      send1(8'hB7, "R8 forced format");

      // R9 parity error halts
      cfg_eot = 1'b0;
      cfg_txen = 1'b0;
      push(8'h21);
      push(8'h42);
      cfg_txen = 1'b1;
      fork
         capture(8'h21, "R9 current frame", 1'b0);
         begin
            repeat (30) @(negedge clk);
            par_err = 1'b1;
            @(negedge clk);
            par_err = 1'b0;
         end
      join
      quiet(600, "R9 halted");
      @(negedge clk);
      abort_clr = 1'b1;
      @(negedge clk);
      abort_clr = 1'b0;
      capture(8'h42, "R9 released", 1'b0);
      cfg_smart = 1'b0; cfg_wlen = 2'd3;
      @(negedge clk);
      par_err = 1'b1;
      @(negedge clk);
      par_err = 1'b0;
      push(8'h99);
      capture(8'h99, "R9 ignored outside card mode", 1'b0);

      // R10 loopback
      cfg_loop = 1'b1;
      rxd_pin = 1'b0;
      @(negedge clk);
      check(rx_in === 1'b1, "R10 loop idle", int'(rx_in), 1);
      push(8'h0F);
      fork
         capture(8'h0F, "R10 frame", 1'b0);
         begin
            int m;
            m = 0;
            repeat (150) begin
               @(negedge clk);
               if (rx_in !== txd) m++;
            end
            check(m == 0, "R10 follows txd", m, 0);
         end
      join
      cfg_loop = 1'b0;
      @(negedge clk);
      check(rx_in === 1'b0, "R10 pin low", int'(rx_in), 0);
      rxd_pin = 1'b1;
      @(negedge clk);
      check(rx_in === 1'b1, "R10 pin high", int'(rx_in), 1);

      // R11 queue depth and drop on full
      cfg_txen = 1'b0;
      for (int i = 0; i < 17; i++) push(8'(i * 29 + 7));
      check(wr_full === 1'b1, "R11 full", int'(wr_full), 1);
      cfg_txen = 1'b1;
      for (int i = 0; i < 16; i++) capture(8'(i * 29 + 7), "R11 queued byte", 1'b0);
      quiet(500, "R11 extra dropped");
      check(wr_full === 1'b0, "R11 drained", int'(wr_full), 0);

      // random formats, rates and data
      cfg_eot = 1'b1;
      for (int n = 0; n < 12; n++) begin
         logic [7:0] d;
         cfg_wlen     = 2'($urandom_range(0, 3));
         cfg_par_en   = 1'($urandom_range(0, 1));
         cfg_par_even = 1'($urandom_range(0, 1));
         cfg_two_stop = 1'($urandom_range(0, 1));
         cfg_fast     = 1'($urandom_range(0, 1));
         cfg_div      = 16'($urandom_range(1, 3));
         d            = 8'($urandom_range(0, 255));
         send1(d, "R2 R3 R7 random");
      end

      finish_run();
   end

endmodule